// File: doc/BRIEF.md
# Branch Mispredict Squash Controller

This block decides which in-flight instructions of a scalar six-stage in-order pipeline are discarded when a branch turns out to be mispredicted. The stages are fetch, decode, issue (where registers are read), two execute stages X0 and X1, and writeback. The branch outcome is known only at the end of X1. On that same clock edge, the four younger stages (fetch, decode, issue, X0) must either keep or lose their contents. The controller drives one kill line per younger stage. The pipeline uses each kill line to clear that stage's valid bit, which turns the stage into a bubble.

A mode input chooses whether the architecture has a branch-delay slot. When the slot is honoured, the instruction that follows the branch must complete in every case. Each younger stage carries a tag bit that marks it as holding that instruction, and the controller spares the tagged stage wherever it sits. The slot instruction may not have been fetched yet, for example after an instruction-cache miss. In that case the controller waits: it keeps the next fetched instruction and issues the redirect in the cycle that instruction arrives.

The redirect is a single-cycle pulse that carries the corrected fetch address. A count of squashed instructions is valid during the same cycle.

Top module: `squash_ctrl`

## Requirements
- R1: With the slot mode off (`slot_mode`=0), a mispredict asserts `kill[s]` for exactly the valid younger stages, in the same cycle. Bit 0 is fetch, bit 1 is decode, bit 2 is issue and bit 3 is X0.
- R2: With the slot mode on, a valid stage whose `slot_tag` bit is set is not killed, and every other valid younger stage is killed in the same cycle.
- R3: A stage whose valid bit is 0 is never killed.
- R4: `squash_cnt` equals the number of stages killed for the event that `redirect_valid` announces, so its range is 0..4 in slot-off mode and 0..3 when a slot instruction is spared. `squash_cnt` is 0 in every cycle without `redirect_valid`.
- R5: When the mispredict is not deferred, `redirect_valid` is 1 in the mispredict cycle and `redirect_pc` equals `target_pc` in that cycle.
- R6: In slot mode, if no valid stage is tagged, the controller kills every valid younger stage, gives no redirect in that cycle, and `slot_wait` reads 1 from the next cycle on.
- R7: While `slot_wait` is 1, the first cycle with `fetch_arrive`=1 gives a single `redirect_valid`. In that cycle `redirect_pc` is the target captured at the mispredict and `squash_cnt` is the count captured at the mispredict. `slot_wait` is 0 from the next cycle on.
- R8: While `slot_wait` is 1, a mispredict has no effect: no kill and no redirect.
- R9: After reset, `slot_wait`, `redirect_valid`, `kill` and `squash_cnt` are all 0.
- R10: `fetch_arrive` while `slot_wait` is 0 produces no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_mode | input | 1 | 1 = honour the branch-delay slot |
| mispredict | input | 1 | Branch in X1 resolved as mispredicted this cycle |
| target_pc | input | PC_W | Corrected fetch address from X1 |
| stage_valid | input | NS | Valid bits of fetch, decode, issue, X0 (bit 0 = fetch) |
| slot_tag | input | NS | Marks the stage holding the delay-slot instruction |
| fetch_arrive | input | 1 | An instruction enters fetch at the coming edge |
| kill | output | NS | Per-stage squash, same bit order as stage_valid |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | PC_W | Address to fetch from after the redirect |
| squash_cnt | output | CW | Number of stages squashed for this redirect |
| slot_wait | output | 1 | Waiting for the delay-slot instruction to be fetched |

## Verification
Kill lines, the immediate redirect and its count are combinational. The bench therefore samples them one time unit after driving inputs on the falling edge, inside the mispredict cycle. `slot_wait` is registered, so it is checked in the cycle after the rising edge that sampled the mispredict. The deferred redirect is checked in the cycle where `fetch_arrive` is driven, and the clearing of `slot_wait` one cycle after that. The sweep covers every valid pattern and every tag position, including no tag, in both modes, against a popcount computed in the bench.

// File: rtl/squash_pkg.sv
package squash_pkg;
    localparam int SQ_YOUNG_STAGES = 4;
    localparam int SQ_PC_W         = 32;

    typedef enum int {
        ST_FETCH = 0,
        ST_DEC   = 1,
        ST_ISS   = 2,
        ST_X0    = 3
    } young_stage_e;
endpackage

// File: rtl/squash_kill_mask.sv
module squash_kill_mask #(
    parameter int NS = squash_pkg::SQ_YOUNG_STAGES
) (
    input  logic          flush,
    input  logic          slot_mode,
    input  logic [NS-1:0] stage_valid,
    input  logic [NS-1:0] slot_tag,
    output logic [NS-1:0] kill,
    output logic          slot_found
);
    logic [NS-1:0] spare;

    // One lane per younger stage: spare the tagged slot instruction in slot mode.
    for (genvar s = 0; s < NS; s++) begin : g_lane
        assign spare[s] = slot_mode & stage_valid[s] & slot_tag[s];
        assign kill[s]  = flush & stage_valid[s] & ~spare[s];
    end

    assign slot_found = |spare;
endmodule

// File: rtl/squash_count.sv
module squash_count #(
    parameter int NS = squash_pkg::SQ_YOUNG_STAGES,
    parameter int CW = $clog2(NS + 1)
) (
    input  logic [NS-1:0] vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < NS; i++) begin
            cnt = cnt + {{(CW-1){1'b0}}, vec[i]};
        end
    end
endmodule

// File: rtl/squash_slot_wait.sv
module squash_slot_wait #(
    parameter int PC_W = squash_pkg::SQ_PC_W,
    parameter int CW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [PC_W-1:0] arm_pc,
    input  logic [CW-1:0]   arm_cnt,
    input  logic            fetch_arrive,
    output logic            waiting,
    output logic            fire,
    output logic [PC_W-1:0] held_pc,
    output logic [CW-1:0]   held_cnt
);
    typedef struct packed {
        logic            waiting;
        logic [PC_W-1:0] pc;
        logic [CW-1:0]   cnt;
    } wait_state_t;

    wait_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = st_q.waiting & fetch_arrive;
        if (arm) begin
            st_d.waiting = 1'b1;
            st_d.pc      = arm_pc;
            st_d.cnt     = arm_cnt;
        end else if (fire) begin
            st_d.waiting = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign waiting  = st_q.waiting;
    assign held_pc  = st_q.pc;
    assign held_cnt = st_q.cnt;
endmodule

// File: rtl/squash_ctrl.sv
module squash_ctrl #(
    parameter int NS   = squash_pkg::SQ_YOUNG_STAGES,
    parameter int PC_W = squash_pkg::SQ_PC_W,
    localparam int CW  = $clog2(NS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot_mode,
    input  logic            mispredict,
    input  logic [PC_W-1:0] target_pc,
    input  logic [NS-1:0]   stage_valid,
    input  logic [NS-1:0]   slot_tag,
    input  logic            fetch_arrive,
    output logic [NS-1:0]   kill,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic [CW-1:0]   squash_cnt,
    output logic            slot_wait
);
    logic          flush;
    logic          slot_found;
    logic          defer;
    logic          now;
    logic          fire;
    logic [CW-1:0] kill_cnt;
    logic [CW-1:0] held_cnt;
    logic [PC_W-1:0] held_pc;

    assign flush = mispredict & ~slot_wait;

    squash_kill_mask #(.NS(NS)) mask_i (
        .flush       (flush),
        .slot_mode   (slot_mode),
        .stage_valid (stage_valid),
        .slot_tag    (slot_tag),
        .kill        (kill),
        .slot_found  (slot_found)
    );

    squash_count #(.NS(NS), .CW(CW)) count_i (
        .vec (kill),
        .cnt (kill_cnt)
    );

    assign defer = flush & slot_mode & ~slot_found;
    assign now   = flush & ~defer;

    squash_slot_wait #(.PC_W(PC_W), .CW(CW)) wait_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (defer),
        .arm_pc       (target_pc),
        .arm_cnt      (kill_cnt),
        .fetch_arrive (fetch_arrive),
        .waiting      (slot_wait),
        .fire         (fire),
        .held_pc      (held_pc),
        .held_cnt     (held_cnt)
    );

    always_comb begin
        redirect_valid = now | fire;
        redirect_pc    = slot_wait ? held_pc : target_pc;
        if (now) begin
            squash_cnt = kill_cnt;
        end else if (fire) begin
            squash_cnt = held_cnt;
        end else begin
            squash_cnt = '0;
        end
    end
endmodule

// File: rtl/squash_ctrl_chk.sv
module squash_ctrl_chk #(
    parameter int NS = 4,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slot_mode,
    input logic          mispredict,
    input logic [NS-1:0] stage_valid,
    input logic [NS-1:0] slot_tag,
    input logic          fetch_arrive,
    input logic [NS-1:0] kill,
    input logic          redirect_valid,
    input logic [CW-1:0] squash_cnt,
    input logic          slot_wait
);
    // R3
    no_bubble_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill & ~stage_valid) == '0);

    // R2
    slot_spared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_mode && mispredict) |-> (kill & slot_tag & stage_valid) == '0);

    // R1
    full_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_mode && mispredict && !slot_wait) |-> kill == stage_valid);

    // R6
    wait_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_mode && mispredict && !slot_wait && (stage_valid & slot_tag) == '0)
        |=> slot_wait);

    // R7
    wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_wait && fetch_arrive) |-> redirect_valid ##1 !slot_wait);

    // R8
    no_kill_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_wait |-> kill == '0);

    // R4
    cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |-> squash_cnt == '0);

    // R10
    redirect_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (mispredict || (slot_wait && fetch_arrive)));
endmodule

bind squash_ctrl squash_ctrl_chk #(.NS(NS), .CW(CW)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_mode      (slot_mode),
    .mispredict     (mispredict),
    .stage_valid    (stage_valid),
    .slot_tag       (slot_tag),
    .fetch_arrive   (fetch_arrive),
    .kill           (kill),
    .redirect_valid (redirect_valid),
    .squash_cnt     (squash_cnt),
    .slot_wait      (slot_wait)
);

// File: tb/squash_ctrl_tb_top.sv
`timescale 1ns/1ps
module squash_ctrl_tb_top;
    localparam int NS   = 4;
    localparam int PC_W = 32;
    localparam int CW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            slot_mode = 1'b0;
    logic            mispredict = 1'b0;
    logic [PC_W-1:0] target_pc = '0;
    logic [NS-1:0]   stage_valid = '0;
    logic [NS-1:0]   slot_tag = '0;
    logic            fetch_arrive = 1'b0;
    logic [NS-1:0]   kill;
    logic            redirect_valid;
    logic [PC_W-1:0] redirect_pc;
    logic [CW-1:0]   squash_cnt;
    logic            slot_wait;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    squash_ctrl #(.NS(NS), .PC_W(PC_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .slot_mode      (slot_mode),
        .mispredict     (mispredict),
        .target_pc      (target_pc),
        .stage_valid    (stage_valid),
        .slot_tag       (slot_tag),
        .fetch_arrive   (fetch_arrive),
        .kill           (kill),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .squash_cnt     (squash_cnt),
        .slot_wait      (slot_wait)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [NS-1:0] v);
        int n = 0;
        for (int i = 0; i < NS; i++) n += int'(v[i]);
        return n;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9 slot_wait", 32'(slot_wait), 0);
        check("R9 redirect_valid", 32'(redirect_valid), 0);
        check("R9 kill", 32'(kill), 0);
        check("R9 squash_cnt", 32'(squash_cnt), 0);
        rst_n = 1'b1;

        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 16; v++) begin
                for (int tp = 0; tp < 5; tp++) begin
                    logic [NS-1:0] vv;
                    logic [NS-1:0] tg;
                    logic [NS-1:0] kexp;
                    logic [31:0]   tgt;
                    bit spared;
                    bit pend;
                    vv     = NS'(v);
                    tg     = (tp < NS) ? NS'(1 << tp) : '0;
                    spared = (m == 1) && (tp < NS) && vv[tp];
                    pend   = (m == 1) && !spared;
                    kexp   = spared ? (vv & ~tg) : vv;
                    tgt    = 32'h4000_0000 + 32'(m * 256 + v * 8 + tp) * 4;

                    @(negedge clk);
                    slot_mode   = m[0];
                    stage_valid = vv;
                    slot_tag    = tg;
                    target_pc   = tgt;
                    mispredict  = 1'b1;
                    #1;
                    check(m == 0 ? "R1 kill" : "R2 kill", 32'(kill), 32'(kexp));
                    check("R3 bubble kill", 32'(kill & ~vv), 0);
                    if (pend) begin
                        check("R6 no immediate redirect", 32'(redirect_valid), 0);
                        check("R4 count idle", 32'(squash_cnt), 0);
                    end else begin
                        check("R5 redirect_valid", 32'(redirect_valid), 1);
                        check("R5 redirect_pc", redirect_pc, tgt);
                        check("R4 count", 32'(squash_cnt), 32'(ones(kexp)));
                    end

                    @(negedge clk);
                    mispredict  = 1'b0;
                    stage_valid = '0;
                    slot_tag    = '0;
                    #1;
                    check("R6 slot_wait", 32'(slot_wait), 32'(pend));
                    check("R4 count after pulse", 32'(squash_cnt), 0);

                    if (pend) begin
                        if (tp == NS) begin
                            // R8: mispredict while waiting is ignored
                            mispredict  = 1'b1;
                            stage_valid = '1;
                            #1;
                            check("R8 kill", 32'(kill), 0);
                            check("R8 redirect", 32'(redirect_valid), 0);
                            @(negedge clk);
                            mispredict  = 1'b0;
                            stage_valid = '0;
                        end
                        target_pc    = 32'hDEAD_BEEC;
                        fetch_arrive = 1'b1;
                        #1;
                        check("R7 redirect_valid", 32'(redirect_valid), 1);
                        check("R7 held pc", redirect_pc, tgt);
                        check("R7 held count", 32'(squash_cnt), 32'(ones(kexp)));
                        @(negedge clk);
                        fetch_arrive = 1'b0;
                        #1;
                        check("R7 wait cleared", 32'(slot_wait), 0);
                        check("R7 single pulse", 32'(redirect_valid), 0);
                    end else if (v == 15) begin
                        fetch_arrive = 1'b1;
                        #1;
                        check("R10 no redirect", 32'(redirect_valid), 0);
                        @(negedge clk);
                        fetch_arrive = 1'b0;
                    end
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule